// File: doc/BRIEF.md
# Twin-Load Banked Data Cache

This block is the lookup and data-array path of a first-level data cache that can retire two 8-byte loads in the same clock. Every 64-byte line is split into eight 8-byte chunks. Chunk k of every line lives in bank k, so address bits [5:3] choose the bank. The tag and valid state is kept in two identical copies, one per load port, so both lookups proceed in parallel. When the two loads need different banks, both are accepted together. When they need the same bank, port 0 wins and port 1 is held off by its ready signal.

Each load port uses a valid/ready handshake. It returns its result one cycle after acceptance, either the 8-byte chunk with a hit flag or a miss flag together with the line address. A line-fill port writes a whole line into all eight banks and both tag copies in one cycle. During that cycle neither load port is ready. The cache is 2-way set associative with one LRU bit per set. The default size is 16 sets, and 512 sets gives 8 KiB per bank.

Top module: `twin_load_bank_cache`

## Requirements
- R1: After reset every line is invalid, so the first lookup misses, and no response is valid until a load has been accepted.
- R2: The bank is addr[5:3]. A hit returns chunk addr[5:3] of the line, and chunk k is fill_data[64k+63:64k].
- R3: With no fill and two valid loads in different banks, both ready signals are high and both loads are accepted in that cycle.
- R4: With no fill and two valid loads in the same bank, req0_ready is high and req1_ready is low. Port 1 is accepted in a later cycle.
- R5: While fill_valid is high, both ready signals are low. The filled line hits on either port from the next cycle on.
- R6: A miss response has rsp_miss=1, rsp_hit=0 and rsp_data=0, and rsp_line is addr[ADDR_W-1:6].
- R7: A response is valid exactly one cycle after its load was accepted, and never otherwise.
- R8: A fill of an absent line goes to way 0 if it is invalid, else way 1 if it is invalid, else the way named by the set's LRU bit. A hit or a fill on way w makes way 1-w the next victim. When both ports hit the same set in one cycle, port 1's update is the one kept.
- R9: A fill whose line is already present rewrites the way that holds it and leaves the other way untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req0_valid | input | 1 | Port 0 load request |
| req0_addr | input | ADDR_W | Port 0 byte address (bits [2:0] ignored) |
| req0_ready | output | 1 | Port 0 can accept |
| req1_valid | input | 1 | Port 1 load request |
| req1_addr | input | ADDR_W | Port 1 byte address (bits [2:0] ignored) |
| req1_ready | output | 1 | Port 1 can accept |
| fill_valid | input | 1 | Write a whole line this cycle |
| fill_addr | input | ADDR_W | Address of the line being filled (bits [5:0] ignored) |
| fill_data | input | 512 | Line contents, chunk k in bits [64k+63:64k] |
| rsp0_valid | output | 1 | Port 0 result valid |
| rsp0_hit | output | 1 | Port 0 hit |
| rsp0_miss | output | 1 | Port 0 miss |
| rsp0_data | output | 64 | Port 0 chunk, zero on a miss |
| rsp0_line | output | ADDR_W-6 | Port 0 line address |
| rsp1_valid | output | 1 | Port 1 result valid |
| rsp1_hit | output | 1 | Port 1 hit |
| rsp1_miss | output | 1 | Port 1 miss |
| rsp1_data | output | 64 | Port 1 chunk, zero on a miss |
| rsp1_line | output | ADDR_W-6 | Port 1 line address |

## Verification
Two things can fall in the same cycle. The first is a line fill arriving while both ports hold loads. The second is two hits landing in the same set and each wanting to move that set's LRU bit. The bench drives directed cases of each: loads held pending across a fill, and port 0 and port 1 hitting opposite ways of one set followed by a fill that must evict the way port 1 did not touch. It then runs a random mix on a few sets and tags, where such collisions are frequent. Every ready value and every response is compared with a model built from the handshake and replacement rules.

// File: rtl/twin_load_bank_cache.sv
module twin_load_bank_cache #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req0_valid,
  input  logic [ADDR_W-1:0] req0_addr,
  output logic              req0_ready,
  input  logic              req1_valid,
  input  logic [ADDR_W-1:0] req1_addr,
  output logic              req1_ready,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [511:0]      fill_data,
  output logic              rsp0_valid,
  output logic              rsp0_hit,
  output logic              rsp0_miss,
  output logic [63:0]       rsp0_data,
  output logic [ADDR_W-7:0] rsp0_line,
  output logic              rsp1_valid,
  output logic              rsp1_hit,
  output logic              rsp1_miss,
  output logic [63:0]       rsp1_data,
  output logic [ADDR_W-7:0] rsp1_line
);
  localparam int BANKS   = 8;
  localparam int WAYS    = 2;
  localparam int CHUNK_W = 64;
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - 6 - IDX_W;
  localparam int LINE_W  = ADDR_W - 6;

  logic [CHUNK_W-1:0] bank_mem [BANKS][WAYS][SETS];
  logic [TAG_W-1:0]   tag_cp   [2][WAYS][SETS];
  logic [WAYS-1:0]    vld_cp   [2][SETS];
  logic [SETS-1:0]    lru;

  logic [1:0][ADDR_W-1:0] addr;
  logic [1:0]             req_v;
  logic [1:0]             rdy;
  logic                   conflict;

  assign addr     = {req1_addr, req0_addr};
  assign req_v    = {req1_valid, req0_valid};
  assign conflict = req0_valid && req1_valid && (req0_addr[5:3] == req1_addr[5:3]);
  assign rdy      = {!fill_valid && !conflict, !fill_valid};
  assign req0_ready = rdy[0];
  assign req1_ready = rdy[1];

  wire unused_bits = ^{req0_addr[2:0], req1_addr[2:0], fill_addr[5:0]};

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [2:0]         bank;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tg;
    logic [WAYS-1:0]    way_hit;
    logic               hit, hway, acc;
    logic               q_valid, q_hit;
    logic [CHUNK_W-1:0] q_data;
    logic [LINE_W-1:0]  q_line;

    assign bank = addr[p][5:3];
    assign idx  = addr[p][6 +: IDX_W];
    assign tg   = addr[p][ADDR_W-1 -: TAG_W];
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_hit[w] = vld_cp[p][idx][w] && (tag_cp[p][w][idx] == tg);
    end
    assign hit  = |way_hit;
    assign hway = way_hit[1];
    assign acc  = req_v[p] && rdy[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q_hit   <= 1'b0;
        q_data  <= '0;
        q_line  <= '0;
      end else begin
        q_valid <= acc;
        if (acc) begin
          q_hit  <= hit;
          q_data <= hit ? bank_mem[bank][hway][idx] : '0;
          q_line <= addr[p][ADDR_W-1:6];
        end
      end
    end
  end

  assign rsp0_valid = g_port[0].q_valid;
  assign rsp0_hit   = g_port[0].q_valid && g_port[0].q_hit;
  assign rsp0_miss  = g_port[0].q_valid && !g_port[0].q_hit;
  assign rsp0_data  = g_port[0].q_data;
  assign rsp0_line  = g_port[0].q_line;
  assign rsp1_valid = g_port[1].q_valid;
  assign rsp1_hit   = g_port[1].q_valid && g_port[1].q_hit;
  assign rsp1_miss  = g_port[1].q_valid && !g_port[1].q_hit;
  assign rsp1_data  = g_port[1].q_data;
  assign rsp1_line  = g_port[1].q_line;

  logic [IDX_W-1:0] fidx;
  logic [TAG_W-1:0] ftag;
  logic [WAYS-1:0]  fmatch;
  logic             fway;

  assign fidx = fill_addr[6 +: IDX_W];
  assign ftag = fill_addr[ADDR_W-1 -: TAG_W];
  for (genvar w = 0; w < WAYS; w++) begin : g_fmatch
    assign fmatch[w] = vld_cp[0][fidx][w] && (tag_cp[0][w][fidx] == ftag);
  end
  assign fway = fmatch[0]              ? 1'b0 :
                fmatch[1]              ? 1'b1 :
                !vld_cp[0][fidx][0]    ? 1'b0 :
                !vld_cp[0][fidx][1]    ? 1'b1 : lru[fidx];

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      for (int k = 0; k < BANKS; k++)
        bank_mem[k][fway][fidx] <= fill_data[k*CHUNK_W +: CHUNK_W];
      for (int c = 0; c < 2; c++)
        tag_cp[c][fway][fidx] <= ftag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < SETS; s++)
          vld_cp[c][s] <= '0;
      lru <= '0;
    end else if (fill_valid) begin
      for (int c = 0; c < 2; c++)
        vld_cp[c][fidx][fway] <= 1'b1;
      lru[fidx] <= !fway;
    end else begin
      if (g_port[0].acc && g_port[0].hit) lru[g_port[0].idx] <= !g_port[0].hway;
      if (g_port[1].acc && g_port[1].hit) lru[g_port[1].idx] <= !g_port[1].hway;
    end
  end
endmodule

// File: rtl/twin_load_bank_cache_props.sv
module twin_load_bank_cache_props #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req0_valid,
  input logic [ADDR_W-1:0] req0_addr,
  input logic              req0_ready,
  input logic              req1_valid,
  input logic [ADDR_W-1:0] req1_addr,
  input logic              req1_ready,
  input logic              fill_valid,
  input logic              rsp0_valid,
  input logic              rsp0_hit,
  input logic              rsp0_miss,
  input logic [63:0]       rsp0_data,
  input logic              rsp1_valid,
  input logic              rsp1_hit,
  input logic              rsp1_miss,
  input logic [63:0]       rsp1_data
);
  p_same_bank_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_valid && req1_valid && req0_addr[5:3] == req1_addr[5:3]) |-> !req1_ready);

  p_port0_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_valid && !fill_valid) |-> req0_ready);

  p_split_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_valid && req1_valid && req0_addr[5:3] != req1_addr[5:3] && !fill_valid)
      |-> (req0_ready && req1_ready));

  p_fill_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (!req0_ready && !req1_ready));

  p_rsp0_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_valid && req0_ready) |=> rsp0_valid);

  p_rsp0_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req0_valid && req0_ready) |=> !rsp0_valid);

  p_rsp1_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req1_valid && req1_ready) |=> rsp1_valid);

  p_rsp1_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req1_valid && req1_ready) |=> !rsp1_valid);

  p_miss0_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp0_valid && rsp0_miss) |-> (!rsp0_hit && rsp0_data == '0));

  p_miss1_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp1_valid && rsp1_miss) |-> (!rsp1_hit && rsp1_data == '0));
endmodule

bind twin_load_bank_cache twin_load_bank_cache_props #(.ADDR_W(ADDR_W)) u_props (
  .clk(clk), .rst_n(rst_n),
  .req0_valid(req0_valid), .req0_addr(req0_addr), .req0_ready(req0_ready),
  .req1_valid(req1_valid), .req1_addr(req1_addr), .req1_ready(req1_ready),
  .fill_valid(fill_valid),
  .rsp0_valid(rsp0_valid), .rsp0_hit(rsp0_hit), .rsp0_miss(rsp0_miss), .rsp0_data(rsp0_data),
  .rsp1_valid(rsp1_valid), .rsp1_hit(rsp1_hit), .rsp1_miss(rsp1_miss), .rsp1_data(rsp1_data)
);

// File: tb/twin_load_bank_cache_test.sv
module twin_load_bank_cache_test;
  logic clk = 1'b0;
  logic rst_n;
  logic req0_valid, req0_ready, req1_valid, req1_ready, fill_valid;
  logic [31:0] req0_addr, req1_addr, fill_addr;
  logic [511:0] fill_data;
  logic rsp0_valid, rsp0_hit, rsp0_miss, rsp1_valid, rsp1_hit, rsp1_miss;
  logic [63:0] rsp0_data, rsp1_data;
  logic [25:0] rsp0_line, rsp1_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twin_load_bank_cache #(.ADDR_W(32), .SETS(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .req0_valid(req0_valid), .req0_addr(req0_addr), .req0_ready(req0_ready),
    .req1_valid(req1_valid), .req1_addr(req1_addr), .req1_ready(req1_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .rsp0_valid(rsp0_valid), .rsp0_hit(rsp0_hit), .rsp0_miss(rsp0_miss),
    .rsp0_data(rsp0_data), .rsp0_line(rsp0_line),
    .rsp1_valid(rsp1_valid), .rsp1_hit(rsp1_hit), .rsp1_miss(rsp1_miss),
    .rsp1_data(rsp1_data), .rsp1_line(rsp1_line)
  );

  logic        mv [16][2];
  logic [21:0] mt [16][2];
  logic        ml [16];

  logic        p0, p1, fv;
  logic [31:0] a0, a1, fa;

  function automatic logic [63:0] dat(input logic [25:0] ln, input logic [2:0] k);
    return {ln, k, 3'b000, ln ^ 26'h2AA_AAAA, k, 3'b111};
  endfunction

  function automatic logic [511:0] line_data(input logic [25:0] ln);
    logic [511:0] v;
    for (int k = 0; k < 8; k++) v[k*64 +: 64] = dat(ln, 3'(k));
    return v;
  endfunction

  function automatic logic [31:0] mk(input int tg, input int st, input int bk);
    return {22'(tg), 4'(st), 3'(bk), 3'b000};
  endfunction

  task automatic chk(input bit ok, input string tg, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] a, output logic h, output logic w);
    h = 1'b0; w = 1'b0;
    for (int i = 0; i < 2; i++)
      if (mv[a[9:6]][i] && mt[a[9:6]][i] == a[31:10]) begin h = 1'b1; w = 1'(i); end
  endtask

  task automatic model_fill(input logic [31:0] a);
    logic h, w;
    lookup(a, h, w);
    if (!h) begin
      if (!mv[a[9:6]][0]) w = 1'b0;
      else if (!mv[a[9:6]][1]) w = 1'b1;
      else w = ml[a[9:6]];
    end
    mv[a[9:6]][w] = 1'b1;
    mt[a[9:6]][w] = a[31:10];
    ml[a[9:6]] = !w;
  endtask

  task automatic step(input string tg);
    logic e0, e1, acc0, acc1, h0, h1, w0, w1;
    string rt;
    req0_valid = p0; req0_addr = a0;
    req1_valid = p1; req1_addr = a1;
    fill_valid = fv; fill_addr = fa; fill_data = line_data(fa[31:6]);
    #1;
    e0 = !fv;
    e1 = !fv && !(p0 && p1 && a0[5:3] == a1[5:3]);
    rt = fv ? "R5" : ((p0 && p1 && a0[5:3] == a1[5:3]) ? "R4" : "R3");
    chk(req0_ready == e0, rt, "req0_ready", 64'(req0_ready), 64'(e0));
    chk(req1_ready == e1, rt, "req1_ready", 64'(req1_ready), 64'(e1));
    acc0 = p0 && e0;
    acc1 = p1 && e1;
    lookup(a0, h0, w0);
    lookup(a1, h1, w1);
    if (fv) model_fill(fa);
    else begin
      if (acc0 && h0) ml[a0[9:6]] = !w0;
      if (acc1 && h1) ml[a1[9:6]] = !w1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rsp0_valid == acc0, "R7", "rsp0_valid", 64'(rsp0_valid), 64'(acc0));
    chk(rsp1_valid == acc1, "R7", "rsp1_valid", 64'(rsp1_valid), 64'(acc1));
    if (acc0) begin
      chk(rsp0_hit == h0, tg, "rsp0_hit", 64'(rsp0_hit), 64'(h0));
      chk(rsp0_miss == !h0, "R6", "rsp0_miss", 64'(rsp0_miss), 64'(!h0));
      chk(rsp0_data == (h0 ? dat(a0[31:6], a0[5:3]) : 64'd0), "R2", "rsp0_data",
          rsp0_data, h0 ? dat(a0[31:6], a0[5:3]) : 64'd0);
      chk(rsp0_line == a0[31:6], "R6", "rsp0_line", 64'(rsp0_line), 64'(a0[31:6]));
    end
    if (acc1) begin
      chk(rsp1_hit == h1, tg, "rsp1_hit", 64'(rsp1_hit), 64'(h1));
      chk(rsp1_miss == !h1, "R6", "rsp1_miss", 64'(rsp1_miss), 64'(!h1));
      chk(rsp1_data == (h1 ? dat(a1[31:6], a1[5:3]) : 64'd0), "R2", "rsp1_data",
          rsp1_data, h1 ? dat(a1[31:6], a1[5:3]) : 64'd0);
      chk(rsp1_line == a1[31:6], "R6", "rsp1_line", 64'(rsp1_line), 64'(a1[31:6]));
    end
    if (acc0) p0 = 1'b0;
    if (acc1) p1 = 1'b0;
    fv = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_unused;
    seed_unused = $urandom(32'd7319);
    for (int s = 0; s < 16; s++) begin
      mv[s][0] = 1'b0; mv[s][1] = 1'b0; mt[s][0] = '0; mt[s][1] = '0; ml[s] = 1'b0;
    end
    p0 = 0; p1 = 0; fv = 0; a0 = '0; a1 = '0; fa = '0;
    req0_valid = 0; req1_valid = 0; fill_valid = 0;
    req0_addr = '0; req1_addr = '0; fill_addr = '0; fill_data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(rsp0_valid == 1'b0, "R1", "rsp0_valid after reset", 64'(rsp0_valid), 64'd0);
    chk(rsp1_valid == 1'b0, "R1", "rsp1_valid after reset", 64'(rsp1_valid), 64'd0);
    step("R1");
    p0 = 1; a0 = mk(1, 5, 2); p1 = 1; a1 = mk(2, 9, 7); step("R1");

    fv = 1; fa = mk(1, 5, 0);
    p0 = 1; a0 = mk(1, 5, 3); p1 = 1; a1 = mk(1, 5, 6); step("R5");
    step("R3");

    p0 = 1; a0 = mk(1, 5, 4); p1 = 1; a1 = mk(1, 5, 4); step("R4");
    chk(p1 == 1'b1, "R4", "port1 still pending", 64'(p1), 64'd1);
    step("R4");

    fv = 1; fa = mk(2, 5, 0); step("R8");
    p0 = 1; a0 = mk(1, 5, 1); step("R8");
    fv = 1; fa = mk(3, 5, 0); step("R8");
    p0 = 1; a0 = mk(1, 5, 7); p1 = 1; a1 = mk(2, 5, 0); step("R8");
    p0 = 1; a0 = mk(1, 5, 2); p1 = 1; a1 = mk(3, 5, 5); step("R8");
    fv = 1; fa = mk(2, 5, 0); step("R8");
    p0 = 1; a0 = mk(1, 5, 0); p1 = 1; a1 = mk(3, 5, 1); step("R8");

    fv = 1; fa = mk(3, 5, 0); step("R9");
    p0 = 1; a0 = mk(2, 5, 3); p1 = 1; a1 = mk(3, 5, 7); step("R9");

    for (int k = 0; k < 8; k++) begin
      p0 = 1; a0 = mk(3, 5, k); p1 = 1; a1 = mk(2, 5, (k + 1) % 8); step("R2");
    end

    for (int i = 0; i < 3000; i++) begin
      if (!p0 && ($urandom % 4) != 0) begin
        p0 = 1; a0 = mk(1 + $urandom % 4, $urandom % 4, $urandom % 8);
      end
      if (!p1 && ($urandom % 4) != 0) begin
        p1 = 1; a1 = mk(1 + $urandom % 4, $urandom % 4, $urandom % 8);
      end
      if (($urandom % 10) == 0) begin
        fv = 1; fa = mk(1 + $urandom % 4, $urandom % 4, 0);
      end
      step("R8");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule